// File: doc/BRIEF.md
# Transmit Descriptor Ring Controller

This block walks a circular ring of transmit descriptors and moves the bytes of each owned buffer into a transmit FIFO. Each descriptor is one memory word. The word holds an ownership flag, frame-start and frame-end markers, three status bits, a byte count and a buffer address. The controller reads and writes these words through a synchronous descriptor port that has one cycle of read latency. It reads buffer bytes through a second synchronous port that also has one cycle of latency. It gives a buffer back to the host by writing its descriptor with the ownership flag cleared.

While a non-final buffer streams, the controller reads the following descriptor once and keeps a copy of it. When the current buffer is drained, that copy decides what happens next. If the following descriptor is owned, the controller moves straight on to it. If it is not owned, the controller records an underflow and stops the transmitter until the next `tx_init`. A transmit error aborts the current buffer. The controller then walks forward and releases the orphaned chained descriptors. After every finished operation the controller polls again at once. When it is idle, a timer triggers the poll. A transmit-done flag with enable and mask inputs drives the interrupt.

The control FSM has six states:

- ST_IDLE waits for the poll timer and goes to ST_FETCH when it fires.
- ST_FETCH reads the descriptor at the ring index and always goes to ST_EXAMINE.
- ST_EXAMINE inspects the returned word:
  - not owned: back to ST_IDLE;
  - owned with frame-start clear: release it and return to ST_FETCH;
  - owned with frame-start set: go to ST_STREAM.
- ST_STREAM moves bytes and issues the lookahead read. It goes to ST_RETIRE when the buffer is drained or when an error arrives.
- ST_RETIRE writes the descriptor back, then takes one of three exits:
  - to ST_FETCH after a frame end or an error;
  - to ST_STREAM when chaining into an owned next buffer;
  - to ST_HALT on underflow.
- ST_HALT is left only by `tx_init`. `tx_init` forces ST_IDLE from any state.

Top module: `txring_ctrl`

## Requirements
- R1: After reset `tx_on`, `tdone`, `irq` and `fifo_wr` are low, and no descriptor read occurs until `tx_init` is pulsed. `tx_init` sets `tx_on` high and the ring index to 0.
- R2: While idle with `tx_on` high, the controller reads the descriptor at the ring index every POLL_CYC cycles. An owned frame start placed while idle therefore produces its first FIFO byte within POLL_CYC+6 cycles.
- R3: Descriptor word layout, from MSB down: own (bit DESC_W-1), sof, eof, berr, uflo, err, count (CNT_W bits), buffer address (BUF_AW bits, the LSBs).
  - Buffer bytes are requested in ascending address order, exactly `count` of them.
  - `buf_rd` is asserted only while `fifo_full` is low.
  - `buf_rdata` is valid the cycle after `buf_rd`, and `fifo_wr` with that byte follows one cycle after each `buf_rd`.
- R4: When a buffer with eof is drained, its descriptor is written back with own, berr, uflo and err all 0, and the ring index advances. The index wraps to 0 after RING_LEN-1.
- R5: An owned descriptor with count 0 moves no data and is written back with own cleared. If such a descriptor has sof clear and eof set, berr is also set in its written status.
- R6: For each buffer without eof, exactly one lookahead read of the next ring descriptor is issued. It comes after the buffer's first byte request, or immediately if the count is 0. No lookahead is issued for a buffer with eof.
- R7: If the looked-ahead descriptor is owned, the drained buffer is written back with own cleared and status bits 0. Streaming then continues from the next buffer, so the frame's bytes arrive contiguously.
- R8: If the looked-ahead descriptor is not owned, the current buffer is still fully streamed. Its descriptor is then written back with own 0 and berr and uflo set. `tx_on` falls, and no further data moves and no poll occurs until `tx_init`.
- R9: A `tx_err` pulse while bytes of the current buffer remain stops byte requests. The current descriptor is written back with own 0 and err set, and no byte is taken from any chained buffer of that frame.
- R10: After an error, and during any poll, owned descriptors with sof clear are written back with own cleared and skipped. The walk stops at a descriptor that is not owned, or starts the frame at an owned one with sof set.
- R11: After any write-back that ends a frame, the next descriptor is fetched immediately, without waiting for the poll interval.
- R12: `tdone` is set by every write-back that ends a frame (normal end, error or underflow) and is cleared by `tdone_clr`. `irq` is high exactly when `tdone` is high, `int_en` is high and `tdone_mask` is low.
- R13: The descriptor port never reads and writes in the same cycle. Every descriptor write carries own = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_init | input | 1 | Re-initialise: index to 0, transmitter on |
| desc_addr | output | IDX_W | Descriptor ring index for read or write |
| desc_rd | output | 1 | Descriptor read request |
| desc_wr | output | 1 | Descriptor write request |
| desc_wdata | output | DESC_W | Descriptor write word |
| desc_rdata | input | DESC_W | Descriptor read word, valid one cycle after the read |
| buf_addr | output | BUF_AW | Buffer byte address |
| buf_rd | output | 1 | Buffer byte read request |
| buf_rdata | input | 8 | Buffer byte, valid one cycle after the read |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write byte |
| fifo_full | input | 1 | FIFO cannot accept a new request (one-cycle early) |
| tx_err | input | 1 | Transmit error pulse |
| tx_on | output | 1 | Transmitter enabled |
| int_en | input | 1 | Global interrupt enable |
| tdone_mask | input | 1 | Transmit-done interrupt mask |
| tdone_clr | input | 1 | Write-one-to-clear strobe for tdone |
| tdone | output | 1 | Transmit-done flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with RING_LEN = 4 and POLL_CYC = 40. The short ring lets five single-buffer frames wrap the index. It also lets one chained frame plus a following frame occupy indices 2, 3 and 0, which crosses the wrap during chaining and the immediate poll. A 40-cycle poll interval is long enough to tell an immediate poll (a handful of cycles) from a timed one, and short enough to sit through several intervals while halted after an underflow.

// File: rtl/txr_pkg.sv
package txr_pkg;
    parameter int CNT_W  = 8;
    parameter int BUF_AW = 12;
    parameter int BYTE_W = 8;

    typedef struct packed {
        logic              own;
        logic              sof;
        logic              eof;
        logic              berr;
        logic              uflo;
        logic              err;
        logic [CNT_W-1:0]  cnt;
        logic [BUF_AW-1:0] addr;
    } txd_t;

    localparam int DESC_W = $bits(txd_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXAMINE,
        ST_STREAM,
        ST_RETIRE,
        ST_HALT
    } txr_state_t;
endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
    parameter int POLL_CYC = 64,
    localparam int CW = $clog2(POLL_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fire
);
    logic [CW-1:0] cnt;

    assign fire = run && (cnt == CW'(POLL_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || fire)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/txr_irq.sv
module txr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic int_en,
    input  logic mask,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign irq = flag && int_en && !mask;
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl import txr_pkg::*; #(
    parameter int RING_LEN = 8,
    parameter int POLL_CYC = 64,
    localparam int IDX_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_init,
    output logic [IDX_W-1:0]  desc_addr,
    output logic              desc_rd,
    output logic              desc_wr,
    output logic [DESC_W-1:0] desc_wdata,
    input  logic [DESC_W-1:0] desc_rdata,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_rd,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_full,
    input  logic              tx_err,
    output logic              tx_on,
    input  logic              int_en,
    input  logic              tdone_mask,
    input  logic              tdone_clr,
    output logic              tdone,
    output logic              irq
);
    txr_state_t        state, state_n;
    logic [IDX_W-1:0]  idx, idx_nx;
    txd_t              cur, nxt, rd_word, wb_word, rel_word;
    logic [BUF_AW-1:0] ptr;
    logic [CNT_W-1:0]  rem;
    logic              la_done, la_pend, moved, err_hit, txon_q, rd_pend;
    logic              buf_go, la_go, err_go, buf_done, fatal, tdone_set, poll_fire;

    assign rd_word   = txd_t'(desc_rdata);
    assign idx_nx    = (idx == IDX_W'(RING_LEN - 1)) ? '0 : idx + 1'b1;
    assign tx_on     = txon_q;
    assign fifo_wr   = rd_pend;
    assign fifo_data = buf_rdata;

    assign buf_go   = (state == ST_STREAM) && (rem != '0) && !fifo_full && !tx_err;
    assign la_go    = (state == ST_STREAM) && !cur.eof && !la_done && (moved || rem == '0);
    assign err_go   = (state == ST_STREAM) && tx_err && (rem != '0);
    assign buf_done = (state == ST_STREAM) && (rem == '0) && (cur.eof || (la_done && !la_pend));
    assign fatal    = !err_hit && !cur.eof && !nxt.own;

    always_comb begin
        wb_word      = cur;
        wb_word.own  = 1'b0;
        wb_word.err  = err_hit;
        wb_word.uflo = fatal;
        wb_word.berr = fatal || (!cur.sof && cur.eof && cur.cnt == '0);
        rel_word     = rd_word;
        rel_word.own = 1'b0;
    end

    txr_poll_timer #(.POLL_CYC(POLL_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == ST_IDLE && txon_q),
        .fire (poll_fire)
    );

    txr_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (tdone_set),
        .clr   (tdone_clr),
        .int_en(int_en),
        .mask  (tdone_mask),
        .flag  (tdone),
        .irq   (irq)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state <= ST_IDLE;
        else if (tx_init) state <= ST_IDLE;
        else              state <= state_n;
    end

    // Next state and memory-port outputs
    always_comb begin
        state_n    = state;
        desc_rd    = la_go;
        desc_wr    = 1'b0;
        desc_addr  = la_go ? idx_nx : idx;
        desc_wdata = wb_word;
        buf_rd     = buf_go;
        buf_addr   = ptr;
        tdone_set  = 1'b0;
        unique case (state)
            ST_IDLE:  if (poll_fire) state_n = ST_FETCH;
            ST_FETCH: begin
                desc_rd = 1'b1;
                state_n = ST_EXAMINE;
            end
            ST_EXAMINE: begin
                if (!rd_word.own) begin
                    state_n = ST_IDLE;
                end else if (!rd_word.sof) begin
                    desc_wr    = 1'b1;
                    desc_wdata = rel_word;
                    state_n    = ST_FETCH;
                end else begin
                    state_n = ST_STREAM;
                end
            end
            ST_STREAM: if (err_go || buf_done) state_n = ST_RETIRE;
            ST_RETIRE: begin
                desc_wr = 1'b1;
                if (err_hit || cur.eof) begin
                    tdone_set = 1'b1;
                    state_n   = ST_FETCH;
                end else if (nxt.own) begin
                    state_n = ST_STREAM;
                end else begin
                    tdone_set = 1'b1;
                    state_n   = ST_HALT;
                end
            end
            ST_HALT: state_n = ST_HALT;
            default: state_n = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            cur     <= '0;
            nxt     <= '0;
            ptr     <= '0;
            rem     <= '0;
            la_done <= 1'b0;
            la_pend <= 1'b0;
            moved   <= 1'b0;
            err_hit <= 1'b0;
            txon_q  <= 1'b0;
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= buf_go;
            la_pend <= la_go;
            if (la_pend) nxt <= rd_word;
            if (tx_init) begin
                idx    <= '0;
                txon_q <= 1'b1;
            end else begin
                unique case (state)
                    ST_EXAMINE: begin
                        if (rd_word.own && !rd_word.sof) begin
                            idx <= idx_nx;
                        end else if (rd_word.own) begin
                            cur     <= rd_word;
                            ptr     <= rd_word.addr;
                            rem     <= rd_word.cnt;
                            la_done <= 1'b0;
                            moved   <= 1'b0;
                            err_hit <= 1'b0;
                        end
                    end
                    ST_STREAM: begin
                        if (buf_go) begin
                            ptr   <= ptr + 1'b1;
                            rem   <= rem - 1'b1;
                            moved <= 1'b1;
                        end
                        if (la_go)  la_done <= 1'b1;
                        if (err_go) err_hit <= 1'b1;
                    end
                    ST_RETIRE: begin
                        if (err_hit || cur.eof) begin
                            idx <= idx_nx;
                        end else if (nxt.own) begin
                            idx     <= idx_nx;
                            cur     <= nxt;
                            ptr     <= nxt.addr;
                            rem     <= nxt.cnt;
                            la_done <= 1'b0;
                            moved   <= 1'b0;
                        end else begin
                            txon_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/txring_ctrl_chk.sv
module txring_ctrl_chk import txr_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_rd,
    input logic              desc_wr,
    input logic [DESC_W-1:0] desc_wdata,
    input logic              buf_rd,
    input logic              fifo_wr,
    input logic              fifo_full,
    input logic              tx_on,
    input logic              tdone,
    input logic              irq
);
    localparam int OWN_B  = DESC_W - 1;
    localparam int BERR_B = DESC_W - 4;
    localparam int UFLO_B = DESC_W - 5;

    assert_port_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_rd && desc_wr));
    assert_write_releases_R13: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> !desc_wdata[OWN_B]);
    assert_no_read_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> !fifo_full);
    assert_fifo_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(buf_rd));
    assert_done_after_writeback_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdone) |-> $past(desc_wr));
    assert_irq_needs_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tdone);
    assert_halt_after_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_on) |-> $past(desc_wr && desc_wdata[UFLO_B] && desc_wdata[BERR_B]));
    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |-> (!buf_rd && !desc_rd && !desc_wr));
endmodule

bind txring_ctrl txring_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_rd   (desc_rd),
    .desc_wr   (desc_wr),
    .desc_wdata(desc_wdata),
    .buf_rd    (buf_rd),
    .fifo_wr   (fifo_wr),
    .fifo_full (fifo_full),
    .tx_on     (tx_on),
    .tdone     (tdone),
    .irq       (irq)
);

// File: tb/txring_ctrl_tb.sv
module txring_ctrl_tb;
    import txr_pkg::*;
    localparam int CLK_P    = 10;
    localparam int RING_LEN = 4;
    localparam int POLL_CYC = 40;
    localparam int IDX_W    = 2;
    localparam int NV       = 5;
    // count, buffer address, backpressure
    localparam int VEC [NV][3] = '{'{3, 16, 0}, '{1, 100, 0}, '{7, 200, 1}, '{2, 4094, 0}, '{4, 60, 0}};

    logic clk = 1'b0, rst_n = 1'b0, tx_init = 1'b0, tx_err = 1'b0;
    logic int_en = 1'b0, tdone_mask = 1'b0, tdone_clr = 1'b0;
    logic fifo_full = 1'b0, bp_en = 1'b0;
    logic [IDX_W-1:0]  desc_addr;
    logic              desc_rd, desc_wr, buf_rd, fifo_wr, tx_on, tdone, irq;
    logic [DESC_W-1:0] desc_wdata, desc_rdata = '0;
    logic [BUF_AW-1:0] buf_addr;
    logic [7:0]        buf_rdata = '0, fifo_data;

    logic [DESC_W-1:0] dmem [RING_LEN];
    logic              h_wr = 1'b0;
    logic [IDX_W-1:0]  h_idx = '0;
    logic [DESC_W-1:0] h_word = '0;
    logic [7:0]        cap [512];
    int                capc [512];
    int cap_n = 0, cyc = 0, n_rd = 0, n_bpv = 0, n_clash = 0;
    int n_chk = 0, n_fail = 0;
    int ring, base, base2, t0, rd0, ne, got, k;

    txring_ctrl #(.RING_LEN(RING_LEN), .POLL_CYC(POLL_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_init(tx_init),
        .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_wr(desc_wr),
        .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
        .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_full(fifo_full),
        .tx_err(tx_err), .tx_on(tx_on), .int_en(int_en), .tdone_mask(tdone_mask),
        .tdone_clr(tdone_clr), .tdone(tdone), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // Memory, FIFO and port monitor model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < RING_LEN; i++) dmem[i] <= '0;
        end else begin
            if (desc_rd) begin
                desc_rdata <= dmem[desc_addr];
                n_rd <= n_rd + 1;
            end
            if (desc_wr) dmem[desc_addr] <= desc_wdata;
            if (h_wr) dmem[h_idx] <= h_word;
        end
        if (desc_rd && desc_wr) n_clash <= n_clash + 1;
        if (buf_rd) buf_rdata <= buf_addr[7:0] ^ 8'h5A;
        if (buf_rd && fifo_full) n_bpv <= n_bpv + 1;
        if (fifo_wr) begin
            cap[cap_n[8:0]]  <= fifo_data;
            capc[cap_n[8:0]] <= cyc;
            cap_n <= cap_n + 1;
        end
    end

    always @(negedge clk) fifo_full <= bp_en ? ~fifo_full : 1'b0;

    function automatic logic [DESC_W-1:0] mk(bit own, bit sof, bit eof, int cnt, int addr);
        return {own, sof, eof, 3'b000, 8'(cnt), 12'(addr)};
    endfunction

    function automatic int exp_b(int a);
        return (a & 255) ^ 8'h5A;
    endfunction

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(int i, logic [DESC_W-1:0] w);
        h_idx = IDX_W'(i); h_word = w; h_wr = 1'b1;
        tick();
        h_wr = 1'b0;
    endtask

    task automatic wait_done(int lim);
        k = 0;
        while (!tdone && k < lim) begin tick(); k++; end
    endtask

    task automatic clr_done();
        tdone_clr = 1'b1; tick(); tdone_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 tx_on in reset", int'(tx_on), 0);
        check("R1 tdone in reset", int'(tdone), 0);
        check("R1 irq in reset", int'(irq), 0);
        check("R1 fifo_wr in reset", int'(fifo_wr), 0);
        rst_n = 1'b1;
        tick(POLL_CYC + 10);
        check("R1 no poll before init", n_rd, 0);
        tx_init = 1'b1; tick(); tx_init = 1'b0;
        check("R1 tx_on after init", int'(tx_on), 1);
        int_en = 1'b1;
        ring = 0;

        // Vector table: single-buffer frames, last one lands after the wrap
        for (int v = 0; v < NV; v++) begin
            base = cap_n; t0 = cyc; bp_en = VEC[v][2] != 0;
            put(ring, mk(1, 1, 1, VEC[v][0], VEC[v][1]));
            wait_done(POLL_CYC + 4 * VEC[v][0] + 40);
            tick(2);
            bp_en = 1'b0;
            check("R3 byte count", cap_n - base, VEC[v][0]);
            for (int b = 0; b < VEC[v][0]; b++)
                check("R3 byte value", int'(cap[base + b]), exp_b(VEC[v][1] + b));
            check("R2 start within poll interval", int'(capc[base] - t0 <= POLL_CYC + 6), 1);
            check(v == NV - 1 ? "R4 own cleared after wrap" : "R4 own cleared", int'(dmem[ring][DESC_W-1]), 0);
            check("R4 status clear", int'(dmem[ring][DESC_W-4 -: 3]), 0);
            check("R12 irq on done", int'(irq), 1);
            clr_done();
            check("R12 tdone cleared", int'(tdone), 0);
            ring = (ring + 1) % RING_LEN;
        end

        // R5: zero-length single buffer at index 1
        base = cap_n;
        put(1, mk(1, 1, 1, 0, 0));
        wait_done(POLL_CYC + 40);
        tick(2);
        check("R5 zero-length moves no data", cap_n - base, 0);
        check("R5 zero-length own cleared", int'(dmem[1][DESC_W-1]), 0);
        check("R5 legal zero-length no berr", int'(dmem[1][DESC_W-4]), 0);
        clr_done();

        // R6/R7/R11: chain at 2->3, then a frame at 0
        put(3, mk(1, 0, 1, 3, 40));
        put(0, mk(1, 1, 1, 2, 80));
        base = cap_n;
        put(2, mk(1, 1, 0, 4, 20));
        rd0 = n_rd;
        k = 0;
        while (cap_n - base < 9 && k < 2 * POLL_CYC + 100) begin tick(); k++; end
        tick(6);
        check("R7 chained frame byte count", cap_n - base, 9);
        for (int b = 0; b < 4; b++) check("R7 first buffer byte", int'(cap[base + b]), exp_b(20 + b));
        for (int b = 0; b < 3; b++) check("R7 chained buffer byte", int'(cap[base + 4 + b]), exp_b(40 + b));
        for (int b = 0; b < 2; b++) check("R11 next frame byte", int'(cap[base + 7 + b]), exp_b(80 + b));
        check("R11 next frame starts at once", int'(capc[base + 7] - capc[base + 6] <= 8), 1);
        check("R7 first descriptor released", int'(dmem[2][DESC_W-1 -: 6]), 3'b010 << 3);
        check("R7 chained descriptor released", int'(dmem[3][DESC_W-1]), 0);
        check("R7 chained descriptor status", int'(dmem[3][DESC_W-4 -: 3]), 0);
        check("R6 one lookahead per buffer", n_rd - rd0, 4);
        clr_done();

        // R8: next descriptor not owned -> underflow and halt
        put(2, '0);
        base = cap_n;
        put(1, mk(1, 1, 0, 5, 120));
        wait_done(POLL_CYC + 60);
        tick(3);
        check("R8 current buffer finished", cap_n - base, 5);
        check("R8 own cleared", int'(dmem[1][DESC_W-1]), 0);
        check("R8 berr set", int'(dmem[1][DESC_W-4]), 1);
        check("R8 uflo set", int'(dmem[1][DESC_W-5]), 1);
        check("R8 tx_on low", int'(tx_on), 0);
        put(2, mk(1, 1, 1, 2, 0));
        base2 = cap_n;
        tick(2 * POLL_CYC);
        check("R8 no data while halted", cap_n - base2, 0);
        check("R8 descriptor untouched while halted", int'(dmem[2][DESC_W-1]), 1);
        clr_done();
        put(2, '0);
        tx_init = 1'b1; tick(); tx_init = 1'b0;
        check("R1 tx_on after re-init", int'(tx_on), 1);

        // R9/R10: error in first buffer, chained buffers skipped, next frame runs
        put(3, mk(1, 1, 1, 3, 150));
        put(2, mk(1, 0, 1, 4, 400));
        put(1, mk(1, 0, 0, 4, 300));
        base = cap_n;
        put(0, mk(1, 1, 0, 20, 0));
        k = 0;
        while (cap_n - base < 3 && k < POLL_CYC + 40) begin tick(); k++; end
        tx_err = 1'b1; ne = cap_n - base;
        tick();
        tx_err = 1'b0;
        k = 0;
        while (dmem[3][DESC_W-1] && k < 100) begin tick(); k++; end
        tick(4);
        got = cap_n - base;
        check("R9 err bit written", int'(dmem[0][DESC_W-6]), 1);
        check("R9 own cleared on error", int'(dmem[0][DESC_W-1]), 0);
        check("R9 no chained data moved", int'((got - 3 - ne) >= 0 && (got - 3 - ne) <= 1), 1);
        for (int b = 0; b < ne; b++) check("R9 bytes before error", int'(cap[base + b]), exp_b(b));
        check("R10 orphan 1 released", int'(dmem[1][DESC_W-1]), 0);
        check("R10 orphan 2 released", int'(dmem[2][DESC_W-1]), 0);
        check("R10 orphan status untouched", int'(dmem[2][DESC_W-4 -: 3]), 0);
        for (int b = 0; b < 3; b++) check("R10 next frame byte", int'(cap[base + got - 3 + b]), exp_b(150 + b));
        check("R10 next frame released", int'(dmem[3][DESC_W-1]), 0);

        // R12: enable and mask
        check("R12 tdone after error frame", int'(tdone), 1);
        tdone_mask = 1'b1; tick();
        check("R12 masked irq", int'(irq), 0);
        tdone_mask = 1'b0; int_en = 1'b0; tick();
        check("R12 disabled irq", int'(irq), 0);
        int_en = 1'b1; tick();
        check("R12 enabled irq", int'(irq), 1);
        clr_done();
        check("R12 irq after clear", int'(irq), 0);

        // R5: illegal zero-length chained end buffer
        put(1, mk(1, 0, 1, 0, 0));
        base = cap_n;
        put(0, mk(1, 1, 0, 2, 30));
        k = 0;
        while (dmem[1][DESC_W-1] && k < POLL_CYC + 60) begin tick(); k++; end
        tick(4);
        check("R5 illegal zero-length berr", int'(dmem[1][DESC_W-4]), 1);
        check("R5 illegal zero-length released", int'(dmem[1][DESC_W-1]), 0);
        check("R5 first buffer clean", int'(dmem[0][DESC_W-4]), 0);
        check("R5 only first buffer data", cap_n - base, 2);
        clr_done();

        check("R3 no read while full", n_bpv, 0);
        check("R13 no read and write together", n_clash, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule